// File: doc/BRIEF.md
# Dual-Operand Move Effective Address Unit

This unit works out both memory addresses of a data-move instruction in one pass. It also works out any pointer updates that the move causes in a 16-entry, 16-bit working register file. The source operand and the destination operand each pick their own addressing mode. Both operands read the same snapshot of the register file. They also share one 4-bit index-register field and one signed literal offset.

For each operand the unit reports a 16-bit effective address and a "no memory access" flag. It also reports a writeback request made of an enable, a register number and a value. The flag is set when the operand is a register or a literal and not a memory location. When both operands would update the same pointer register, only the destination update is reported.

The unit registers its results, so they appear one clock after the request. Memory access, instruction decode and pipeline control belong to the surrounding logic.

Top module: `eau_move_ea`

## Requirements
- R1: While reset is held and after it is released with no request, `out_valid` is 0, both addresses are 0, and both writeback enables are 0.
- R2: A request sampled with `in_valid` high at a rising edge produces `out_valid` high after that edge with the matching results. A cycle without a request gives `out_valid` 0 and leaves the result ports unchanged.
- R3: Mode 0 (register direct), mode 8 (8-bit literal) and mode 9 (16-bit literal) set that operand's no-memory flag to 1, give an address of 0 and request no writeback.
- R4: Mode 1 (indirect) gives the base register's value as the address, clears the no-memory flag and requests no writeback.
- R5: Mode 2 (post-increment) and mode 3 (post-decrement) give the base register's original value as the address. They request a writeback of that value plus or minus the step, modulo 2^16, to the base register.
- R6: Mode 4 (pre-increment) and mode 5 (pre-decrement) give the base value plus or minus the step as the address. They request a writeback of that same value.
- R7: The step is 1 when `op_byte` is 1 and 2 when `op_byte` is 0.
- R8: Mode 6 (indexed) gives the base value plus the value of the register named by `off_reg`, modulo 2^16. Both operands use the same `off_reg`. No writeback is requested.
- R9: Mode 7 (literal offset) gives the base value plus `lit_off`, sign-extended from 10 bits, modulo 2^16. No writeback is requested.
- R10: Source and destination modes are chosen independently. Each operand's results depend only on its own mode and base register, plus the shared fields.
- R11: When both operands request a writeback to the same register, only the destination writeback is reported and `src_wb_en` is 0.
- R12: Both operands compute from the register values presented with the request. A source update never changes the destination address in the same request.
- R13: Modes 10 to 15 behave as no-memory operands: flag 1, address 0 and no writeback.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| op_byte | input | 1 | 1 = byte operation, 0 = word operation |
| src_mode | input | 4 | Source addressing mode |
| src_reg | input | 4 | Source base register number |
| dst_mode | input | 4 | Destination addressing mode |
| dst_reg | input | 4 | Destination base register number |
| off_reg | input | 4 | Shared index register number |
| lit_off | input | 10 | Shared signed literal offset |
| regs_flat | input | 256 | Register file snapshot, register k at bits [16k+15:16k] |
| out_valid | output | 1 | Results below belong to the previous request |
| src_ea | output | 16 | Source effective address |
| src_nomem | output | 1 | Source makes no memory access |
| dst_ea | output | 16 | Destination effective address |
| dst_nomem | output | 1 | Destination makes no memory access |
| src_wb_en | output | 1 | Source pointer writeback requested |
| src_wb_reg | output | 4 | Source writeback register |
| src_wb_val | output | 16 | Source writeback value |
| dst_wb_en | output | 1 | Destination pointer writeback requested |
| dst_wb_reg | output | 4 | Destination writeback register |
| dst_wb_val | output | 16 | Destination writeback value |

## Verification
The hardest cases to reach are two requests that name the same base register in both operands. The first has both operands modifying that register. The second has only the source modifying it while the destination reads it. These cases expose the writeback priority and the snapshot rule.

Random register numbers seldom line up, so directed requests build exactly these pairings. Byte and word sizes are both used. Pre-decrement of a zero pointer and sums that cross 2^16 are added to hit the wrap-around arithmetic. A long random run with a small register range then mixes modes freely and makes such collisions frequent.

// File: rtl/eau_pkg.sv
package eau_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    AM_DIRECT   = 4'd0,
    AM_IND      = 4'd1,
    AM_POSTINC  = 4'd2,
    AM_POSTDEC  = 4'd3,
    AM_PREINC   = 4'd4,
    AM_PREDEC   = 4'd5,
    AM_INDEXED  = 4'd6,
    AM_LITOFF   = 4'd7,
    AM_LIT8     = 4'd8,
    AM_LIT16    = 4'd9
  } am_e;
endpackage

// File: rtl/eau_operand.sv
module eau_operand
  import eau_pkg::*;
#(
  parameter int DW    = 16,
  parameter int LIT_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode,
  input  logic              op_byte,
  input  logic [DW-1:0]     base_val,
  input  logic [DW-1:0]     index_val,
  input  logic [LIT_W-1:0]  lit_off,
  output logic [DW-1:0]     ea,
  output logic              nomem,
  output logic              wb_en,
  output logic [DW-1:0]     wb_val
);
  function automatic logic [DW-1:0] f_step(input logic byte_op);
    return byte_op ? DW'(1) : DW'(2);
  endfunction

  function automatic logic [DW-1:0] f_sext(input logic [LIT_W-1:0] v);
    return {{(DW-LIT_W){v[LIT_W-1]}}, v};
  endfunction

  function automatic logic [DW-1:0] f_adj(input logic [DW-1:0] b,
                                          input logic [DW-1:0] s,
                                          input logic dec);
    return dec ? (b - s) : (b + s);
  endfunction

  logic [DW-1:0] step;
  logic          is_pre;
  logic          is_post;
  logic          is_dec;
  logic [DW-1:0] moved;

  assign step    = f_step(op_byte);
  assign is_pre  = (mode == AM_PREINC)  || (mode == AM_PREDEC);
  assign is_post = (mode == AM_POSTINC) || (mode == AM_POSTDEC);
  assign is_dec  = (mode == AM_POSTDEC) || (mode == AM_PREDEC);
  assign moved   = f_adj(base_val, step, is_dec);

  always_comb begin
    ea     = '0;
    nomem  = 1'b0;
    wb_en  = 1'b0;
    wb_val = '0;
    case (mode)
      AM_IND:     ea = base_val;
      AM_POSTINC, AM_POSTDEC: begin
        ea     = base_val;
        wb_en  = 1'b1;
        wb_val = moved;
      end
      AM_PREINC, AM_PREDEC: begin
        ea     = moved;
        wb_en  = 1'b1;
        wb_val = moved;
      end
      AM_INDEXED: ea = base_val + index_val;
      AM_LITOFF:  ea = base_val + f_sext(lit_off);
      default:    nomem = 1'b1;
    endcase
  end

  p_nomem_nowb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    nomem |-> (!wb_en && ea == '0));
  p_post_base_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_post |-> (ea == base_val && wb_en));
  p_pre_same_r6: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> (wb_val == ea && wb_en));
  p_step_size_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> ((wb_val - base_val) == (op_byte ? DW'(1) : DW'(2)) ||
               (base_val - wb_val) == (op_byte ? DW'(1) : DW'(2))));
endmodule

// File: rtl/eau_wb_merge.sv
module eau_wb_merge #(
  parameter int RIDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_req,
  input  logic [RIDX_W-1:0] src_idx,
  input  logic              dst_req,
  input  logic [RIDX_W-1:0] dst_idx,
  output logic              src_keep,
  output logic              dst_keep
);
  logic collide;

  assign collide  = src_req && dst_req && (src_idx == dst_idx);
  assign src_keep = src_req && !collide;
  assign dst_keep = dst_req;

  p_dst_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (src_keep && dst_keep) |-> (src_idx != dst_idx));
  p_no_lost_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (src_req && !src_keep) |-> dst_keep);
endmodule

// File: rtl/eau_move_ea.sv
module eau_move_ea
  import eau_pkg::*;
#(
  parameter int DW    = 16,
  parameter int NREG  = 16,
  parameter int LIT_W = 10,
  localparam int RIDX_W = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               op_byte,
  input  logic [MODE_W-1:0]  src_mode,
  input  logic [RIDX_W-1:0]  src_reg,
  input  logic [MODE_W-1:0]  dst_mode,
  input  logic [RIDX_W-1:0]  dst_reg,
  input  logic [RIDX_W-1:0]  off_reg,
  input  logic [LIT_W-1:0]   lit_off,
  input  logic [NREG*DW-1:0] regs_flat,
  output logic               out_valid,
  output logic [DW-1:0]      src_ea,
  output logic               src_nomem,
  output logic [DW-1:0]      dst_ea,
  output logic               dst_nomem,
  output logic               src_wb_en,
  output logic [RIDX_W-1:0]  src_wb_reg,
  output logic [DW-1:0]      src_wb_val,
  output logic               dst_wb_en,
  output logic [RIDX_W-1:0]  dst_wb_reg,
  output logic [DW-1:0]      dst_wb_val
);
  localparam int NOPS = 2;

  logic [DW-1:0] wr [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_unpack
    assign wr[g] = regs_flat[g*DW +: DW];
  end

  logic [MODE_W-1:0] op_mode  [NOPS];
  logic [RIDX_W-1:0] op_reg   [NOPS];
  logic [DW-1:0]     op_ea    [NOPS];
  logic              op_nomem [NOPS];
  logic              op_wben  [NOPS];
  logic [DW-1:0]     op_wbval [NOPS];
  logic [DW-1:0]     index_val;

  assign op_mode[0] = src_mode;
  assign op_mode[1] = dst_mode;
  assign op_reg[0]  = src_reg;
  assign op_reg[1]  = dst_reg;
  assign index_val  = wr[off_reg];

  for (genvar k = 0; k < NOPS; k++) begin : g_op
    eau_operand #(.DW(DW), .LIT_W(LIT_W)) u_op (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (op_mode[k]),
      .op_byte   (op_byte),
      .base_val  (wr[op_reg[k]]),
      .index_val (index_val),
      .lit_off   (lit_off),
      .ea        (op_ea[k]),
      .nomem     (op_nomem[k]),
      .wb_en     (op_wben[k]),
      .wb_val    (op_wbval[k])
    );
  end

  logic src_keep;
  logic dst_keep;

  eau_wb_merge #(.RIDX_W(RIDX_W)) u_merge (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_req  (op_wben[0]),
    .src_idx  (src_reg),
    .dst_req  (op_wben[1]),
    .dst_idx  (dst_reg),
    .src_keep (src_keep),
    .dst_keep (dst_keep)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      src_ea     <= '0;
      src_nomem  <= 1'b0;
      dst_ea     <= '0;
      dst_nomem  <= 1'b0;
      src_wb_en  <= 1'b0;
      src_wb_reg <= '0;
      src_wb_val <= '0;
      dst_wb_en  <= 1'b0;
      dst_wb_reg <= '0;
      dst_wb_val <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        src_ea     <= op_ea[0];
        src_nomem  <= op_nomem[0];
        dst_ea     <= op_ea[1];
        dst_nomem  <= op_nomem[1];
        src_wb_en  <= src_keep;
        src_wb_reg <= src_reg;
        src_wb_val <= op_wbval[0];
        dst_wb_en  <= dst_keep;
        dst_wb_reg <= dst_reg;
        dst_wb_val <= op_wbval[1];
      end
    end
  end

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(src_ea) && $stable(dst_ea)));
  p_out_nomem_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && src_nomem) |-> (src_ea == '0 && !src_wb_en));
  p_out_unique_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && src_wb_en && dst_wb_en) |-> (src_wb_reg != dst_wb_reg));
endmodule

// File: tb/eau_move_ea_bench.sv
`timescale 1ns/1ps
module eau_move_ea_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         op_byte = 1'b0;
  logic [3:0]   src_mode = '0, src_reg = '0, dst_mode = '0, dst_reg = '0, off_reg = '0;
  logic [9:0]   lit_off = '0;
  logic [255:0] regs_flat = '0;
  logic         out_valid, src_nomem, dst_nomem, src_wb_en, dst_wb_en;
  logic [15:0]  src_ea, dst_ea, src_wb_val, dst_wb_val;
  logic [3:0]   src_wb_reg, dst_wb_reg;

  always #2 clk = ~clk;

  eau_move_ea u_eau_move_ea (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_byte(op_byte),
    .src_mode(src_mode), .src_reg(src_reg), .dst_mode(dst_mode), .dst_reg(dst_reg),
    .off_reg(off_reg), .lit_off(lit_off), .regs_flat(regs_flat),
    .out_valid(out_valid), .src_ea(src_ea), .src_nomem(src_nomem),
    .dst_ea(dst_ea), .dst_nomem(dst_nomem), .src_wb_en(src_wb_en),
    .src_wb_reg(src_wb_reg), .src_wb_val(src_wb_val), .dst_wb_en(dst_wb_en),
    .dst_wb_reg(dst_wb_reg), .dst_wb_val(dst_wb_val));

  typedef struct {
    int          stamp;
    string       tag;
    logic [15:0] s_ea, d_ea, s_wv, d_wv;
    logic        s_nm, d_nm, s_we, d_we;
    logic [3:0]  s_wr, d_wr;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   n_cmp = 0;
  int   n_bad = 0;
  logic [15:0] rf [16];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // independent restatement of one operand's behaviour
  task automatic model_op(input logic [3:0] m, input logic [15:0] b,
                          input logic [15:0] ix, input logic [9:0] lo,
                          input logic by, output logic [15:0] ea,
                          output logic nm, output logic we, output logic [15:0] wv);
    logic [15:0] st;
    logic [15:0] slo;
    st  = by ? 16'd1 : 16'd2;
    slo = lo[9] ? (16'hFC00 | {6'd0, lo}) : {6'd0, lo};
    ea = 16'h0; nm = 1'b0; we = 1'b0; wv = 16'h0;
    if (m == 4'd1) ea = b;
    else if (m == 4'd2 || m == 4'd3) begin
      ea = b; we = 1'b1;
      wv = (m == 4'd2) ? b + st : b - st;
    end else if (m == 4'd4 || m == 4'd5) begin
      wv = (m == 4'd4) ? b + st : b - st;
      ea = wv; we = 1'b1;
    end else if (m == 4'd6) ea = b + ix;
    else if (m == 4'd7) ea = b + slo;
    else nm = 1'b1;
  endtask

  task automatic pack_regs();
    for (int i = 0; i < 16; i++) regs_flat[i*16 +: 16] = rf[i];
  endtask

  task automatic issue(input string tag, input logic by,
                       input logic [3:0] sm, input logic [3:0] sr,
                       input logic [3:0] dm, input logic [3:0] dr,
                       input logic [3:0] ofr, input logic [9:0] lo);
    exp_t e;
    @(negedge clk);
    pack_regs();
    op_byte = by; src_mode = sm; src_reg = sr; dst_mode = dm; dst_reg = dr;
    off_reg = ofr; lit_off = lo; in_valid = 1'b1;
    e.tag = tag; e.stamp = cyc;
    model_op(sm, rf[sr], rf[ofr], lo, by, e.s_ea, e.s_nm, e.s_we, e.s_wv);
    model_op(dm, rf[dr], rf[ofr], lo, by, e.d_ea, e.d_nm, e.d_we, e.d_wv);
    if (e.s_we && e.d_we && sr == dr) e.s_we = 1'b0;
    e.s_wr = sr; e.d_wr = dr;
    exp_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor: pop when a result is due, otherwise demand silence
  logic [15:0] hold_s_ea, hold_d_ea;
  always @(negedge clk) begin
    if (rst_n && cyc > 0) begin
      if (exp_q.size() > 0 && exp_q[0].stamp == cyc - 1) begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.tag, "out_valid R2", {15'd0, out_valid}, 16'd1);
        chk(e.tag, "src_ea", src_ea, e.s_ea);
        chk(e.tag, "dst_ea", dst_ea, e.d_ea);
        chk(e.tag, "src_nomem", {15'd0, src_nomem}, {15'd0, e.s_nm});
        chk(e.tag, "dst_nomem", {15'd0, dst_nomem}, {15'd0, e.d_nm});
        chk(e.tag, "src_wb_en", {15'd0, src_wb_en}, {15'd0, e.s_we});
        chk(e.tag, "dst_wb_en", {15'd0, dst_wb_en}, {15'd0, e.d_we});
        if (e.s_we) begin
          chk(e.tag, "src_wb_reg", {12'd0, src_wb_reg}, {12'd0, e.s_wr});
          chk(e.tag, "src_wb_val", src_wb_val, e.s_wv);
        end
        if (e.d_we) begin
          chk(e.tag, "dst_wb_reg", {12'd0, dst_wb_reg}, {12'd0, e.d_wr});
          chk(e.tag, "dst_wb_val", dst_wb_val, e.d_wv);
        end
        hold_s_ea = src_ea;
        hold_d_ea = dst_ea;
      end else if (cyc > 12) begin
        chk("R2", "idle out_valid", {15'd0, out_valid}, 16'd0);
        chk("R2", "idle src_ea hold", src_ea, hold_s_ea);
        chk("R2", "idle dst_ea hold", dst_ea, hold_d_ea);
      end
    end
  end

  bit finished = 1'b0;

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired: actual running expected done");
    summary();
  end

  initial begin
    hold_s_ea = '0; hold_d_ea = '0;
    for (int i = 0; i < 16; i++) rf[i] = 16'h1000 + 16'(i * 16'h0110);
    repeat (3) @(negedge clk);
    chk("R1", "reset out_valid", {15'd0, out_valid}, 16'd0);
    chk("R1", "reset src_ea", src_ea, 16'h0);
    chk("R1", "reset dst_wb_en", {15'd0, dst_wb_en}, 16'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "post-reset out_valid", {15'd0, out_valid}, 16'd0);
    chk("R1", "post-reset src_wb_en", {15'd0, src_wb_en}, 16'd0);
    repeat (8) @(negedge clk);

    // R3 / R13 no-memory modes
    issue("R3", 0, 4'd0, 4'd1, 4'd8, 4'd2, 4'd3, 10'd5);
    issue("R3", 0, 4'd9, 4'd4, 4'd0, 4'd4, 4'd3, 10'd5);
    issue("R13", 1, 4'd10, 4'd1, 4'd15, 4'd2, 4'd3, 10'd5);
    issue("R13", 0, 4'd12, 4'd5, 4'd1, 4'd6, 4'd3, 10'd5);
    // R4 indirect
    issue("R4", 0, 4'd1, 4'd7, 4'd1, 4'd8, 4'd0, 10'd0);
    idle(2);
    // R5 post modify, R7 byte/word
    issue("R5", 0, 4'd2, 4'd1, 4'd3, 4'd2, 4'd0, 10'd0);
    issue("R7", 1, 4'd2, 4'd1, 4'd3, 4'd2, 4'd0, 10'd0);
    // R6 pre modify, R7
    issue("R6", 0, 4'd4, 4'd3, 4'd5, 4'd4, 4'd0, 10'd0);
    issue("R7", 1, 4'd4, 4'd3, 4'd5, 4'd4, 4'd0, 10'd0);
    // wrap at zero
    rf[9] = 16'h0000; rf[10] = 16'hFFFF;
    issue("R6", 0, 4'd5, 4'd9, 4'd4, 4'd10, 4'd0, 10'd0);
    // R8 indexed with shared offset register
    rf[11] = 16'hF000; rf[12] = 16'h2345;
    issue("R8", 0, 4'd6, 4'd1, 4'd6, 4'd11, 4'd12, 10'd0);
    // R9 literal offset positive and negative
    issue("R9", 0, 4'd7, 4'd2, 4'd7, 4'd9, 4'd0, 10'h1FF);
    issue("R9", 1, 4'd7, 4'd2, 4'd7, 4'd9, 4'd0, 10'h200);
    // R10 mixed modes
    issue("R10", 0, 4'd6, 4'd3, 4'd2, 4'd5, 4'd7, 10'd3);
    idle(1);
    // R11 collision: destination wins
    issue("R11", 0, 4'd2, 4'd3, 4'd5, 4'd3, 4'd0, 10'd0);
    issue("R11", 1, 4'd4, 4'd6, 4'd3, 4'd6, 4'd0, 10'd0);
    // different registers: both kept
    issue("R11", 0, 4'd2, 4'd3, 4'd2, 4'd4, 4'd0, 10'd0);
    // R12 source modifies, destination reads the same register
    issue("R12", 0, 4'd2, 4'd1, 4'd1, 4'd1, 4'd0, 10'd0);
    issue("R12", 1, 4'd4, 4'd5, 4'd6, 4'd5, 4'd5, 10'd0);
    idle(3);

    // random mix over a small register range
    for (int t = 0; t < 400; t++) begin
      for (int i = 0; i < 16; i++) rf[i] = 16'($urandom);
      issue("R10", 1'($urandom), 4'($urandom), 4'($urandom_range(0, 3)),
            4'($urandom), 4'($urandom_range(0, 3)), 4'($urandom),
            10'($urandom));
      if (($urandom % 4) == 0) idle(1);
    end
    idle(4);
    chk("R2", "queue drained", 16'(exp_q.size()), 16'd0);
    summary();
  end
endmodule